// File: doc/BRIEF.md
# Double-Rate CPU Bus Bridge

This block lets a processor that runs on a clock exactly twice the system bus rate sit on a host board that was designed for a processor at the base rate. The two clocks come from one phase-locked source, so every slow rising edge lines up with a fast rising edge. The bridge is clocked only by the fast clock. An internal phase bit marks which fast edges are also slow edges. Strobes cross between the two rates on those edges, with no synchronizer stages.

On the processor side, the bridge accepts a one-cycle active-low start strobe with direction, size, address and write data. It answers with one-cycle active-low acknowledge pulses and registered read data. On the board side, it drives a start strobe that lasts a full slow period and keeps address, direction and size steady. It then counts the board's acknowledges until the transfer is finished. When built for a multiplexed host bus, the shared address/data lines carry the captured address while the board start strobe is low, and carry data after that. The autovector acknowledge from the board goes straight through to the processor.

Top module: `xbr_top`

## Requirements
- R1: While reset is high at a clock edge, the next outputs are `brdTsN`=1, `cpuTaN`=1 and `cpuBusy`=0. The fast edge right after reset is released is a slow-aligned edge, and from then on every second fast edge is slow-aligned.
- R2: A low `cpuTsN` is accepted only at an edge where `cpuBusy` is low. `cpuBusy` goes high from that edge until the edge that samples the final board acknowledge. A low `cpuTsN` while `cpuBusy` is high is ignored: it produces no board strobe and leaves the held address unchanged.
- R3: After an acceptance, `brdTsN` goes low at the first slow-aligned edge that follows. It stays low for exactly two fast cycles, once per accepted transfer.
- R4: `brdTaN` is sampled only at slow-aligned edges after the board strobe has ended. Each low sample gives exactly one `cpuTaN` low pulse, one fast cycle wide, which starts at that edge.
- R5: While `cpuTaN` is low, `cpuRdData` equals the `brdRdData` value that was sampled at the same edge as the acknowledge.
- R6: Size code 2'b11 means a line transfer of four beats. Every other size code means one beat. The bridge becomes idle at the edge that samples the last beat.
- R7: `brdAddr`, `brdRw` and `brdSize` take the processor's values at acceptance and hold them until the next acceptance. After reset they are 0, 1 (read) and 0.
- R8: In multiplexed build (the default), `brdAd` carries the held address while `brdTsN` is low, and carries `cpuWrData` otherwise.
- R9: `brdDataOe` is high only while busy, and then only when `brdTsN` is low (multiplexed build) or the transfer is a write (`brdRw`=0).
- R10: `cpuAvecN` follows `brdAvecN` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (processor) clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuTsN | input | 1 | Processor transfer start, active low |
| cpuRw | input | 1 | Direction, 1 = read |
| cpuSize | input | 2 | Size code, 2'b11 = four-beat line |
| cpuAddr | input | AW | Processor address |
| cpuWrData | input | DW | Processor write data |
| cpuTaN | output | 1 | Acknowledge pulse to processor, active low |
| cpuRdData | output | DW | Registered read data |
| cpuBusy | output | 1 | High while a board cycle is in progress |
| cpuAvecN | output | 1 | Autovector acknowledge to processor |
| brdTsN | output | 1 | Stretched board transfer start, active low |
| brdRw | output | 1 | Held direction |
| brdSize | output | 2 | Held size code |
| brdAddr | output | AW | Held address |
| brdAd | output | DW | Board address/data lines (outgoing value) |
| brdDataOe | output | 1 | Enable for driving `brdAd` |
| brdTaN | input | 1 | Board acknowledge, active low |
| brdRdData | input | DW | Board read data |
| brdAvecN | input | 1 | Board autovector acknowledge |

## Verification
The hardest case to reach from the ports is a processor start strobe that arrives while a slow-side burst is still in progress, landing on either phase of the fast clock. The stimulus stalls the board model for several slow periods inside a four-beat line transfer. It then pulses the start strobe with a different address in the middle of that stall. The stimulus also shifts transfer starts by one fast cycle so that acceptance happens on both aligned and unaligned edges. A behavioural model that tracks phase and beats is compared against every output on every cycle.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_ISSUE, ST_WAIT} xbrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture processor request
    logic ack;        // board beat acknowledged on a slow edge
    logic active;     // a transfer is in progress
    logic addrPhase;  // board start strobe is low
  } xbrStrobe_t;

  localparam logic [1:0] SIZE_LINE = 2'b11;
endpackage

// File: rtl/xbr_ctl.sv
module xbr_ctl
  import xbr_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuTsN,
  input  logic [1:0] cpuSize,
  input  logic       brdTaN,
  output logic       brdTsN,
  output logic       cpuTaN,
  output logic       cpuBusy,
  output xbrStrobe_t strobe
);
  localparam int CW = $clog2(BEATS + 1);

  xbrState_e     state;
  logic          phase;
  logic          aligned;
  logic [CW-1:0] beatCnt;
  logic [CW-1:0] beatGoal;
  logic [CW-1:0] nextCnt;

  assign aligned = ~phase;
  assign nextCnt = beatCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      brdTsN   <= 1'b1;
      cpuTaN   <= 1'b1;
      beatCnt  <= '0;
      beatGoal <= '0;
    end else begin
      phase  <= ~phase;
      cpuTaN <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (!cpuTsN) begin
            state    <= ST_PEND;
            beatCnt  <= '0;
            beatGoal <= (cpuSize == SIZE_LINE) ? CW'(BEATS) : CW'(1);
          end
        end
        ST_PEND: begin
          if (aligned) begin
            brdTsN <= 1'b0;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (aligned) begin
            brdTsN <= 1'b1;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (aligned && !brdTaN) begin
            cpuTaN  <= 1'b0;
            beatCnt <= nextCnt;
            if (nextCnt == beatGoal) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpuBusy          = (state != ST_IDLE);
  assign strobe.load      = (state == ST_IDLE) && !cpuTsN;
  assign strobe.ack       = (state == ST_WAIT) && aligned && !brdTaN;
  assign strobe.active    = cpuBusy;
  assign strobe.addrPhase = ~brdTsN;

  // R3
  ts_open_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(brdTsN) |=> !brdTsN);
  // R3
  ts_close_chk: assert property (@(posedge clk) disable iff (rst)
    (!brdTsN && $past(!brdTsN)) |=> brdTsN);
  // R4
  ta_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !cpuTaN |=> cpuTaN);
  // R2
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    !brdTsN |-> cpuBusy);
  // R6
  beat_bound_chk: assert property (@(posedge clk) disable iff (rst)
    beatCnt <= CW'(BEATS));
endmodule

// File: rtl/xbr_path.sv
module xbr_path
  import xbr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter bit MUX_BUS = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  xbrStrobe_t    strobe,
  input  logic          cpuRw,
  input  logic [1:0]    cpuSize,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWrData,
  input  logic [DW-1:0] brdRdData,
  output logic [DW-1:0] cpuRdData,
  output logic [AW-1:0] brdAddr,
  output logic          brdRw,
  output logic [1:0]    brdSize,
  output logic [DW-1:0] brdAd,
  output logic          brdDataOe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brdAddr   <= '0;
      brdRw     <= 1'b1;
      brdSize   <= '0;
      cpuRdData <= '0;
    end else begin
      if (strobe.load) begin
        brdAddr <= cpuAddr;
        brdRw   <= cpuRw;
        brdSize <= cpuSize;
      end
      if (strobe.ack) cpuRdData <= brdRdData;
    end
  end

  generate
    if (MUX_BUS) begin : g_mux
      logic [DW-1:0] addrOnBus;
      if (AW >= DW) begin : g_trim
        assign addrOnBus = brdAddr[DW-1:0];
      end else begin : g_pad
        assign addrOnBus = {{(DW-AW){1'b0}}, brdAddr};
      end
      assign brdAd     = strobe.addrPhase ? addrOnBus : cpuWrData;
      assign brdDataOe = strobe.active && (strobe.addrPhase || !brdRw);
    end else begin : g_split
      assign brdAd     = cpuWrData;
      assign brdDataOe = strobe.active && !brdRw;
    end
  endgenerate

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.active && !strobe.load) |=> ($stable(brdAddr) && $stable(brdRw) && $stable(brdSize)));
endmodule

// File: rtl/xbr_top.sv
module xbr_top
  import xbr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int BEATS   = 4,
  parameter bit MUX_BUS = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpuTsN,
  input  logic          cpuRw,
  input  logic [1:0]    cpuSize,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWrData,
  output logic          cpuTaN,
  output logic [DW-1:0] cpuRdData,
  output logic          cpuBusy,
  output logic          cpuAvecN,
  output logic          brdTsN,
  output logic          brdRw,
  output logic [1:0]    brdSize,
  output logic [AW-1:0] brdAddr,
  output logic [DW-1:0] brdAd,
  output logic          brdDataOe,
  input  logic          brdTaN,
  input  logic [DW-1:0] brdRdData,
  input  logic          brdAvecN
);
  xbrStrobe_t strobe;

  xbr_ctl #(.BEATS(BEATS)) u_ctl (
    .clk(clk), .rst(rst), .cpuTsN(cpuTsN), .cpuSize(cpuSize), .brdTaN(brdTaN),
    .brdTsN(brdTsN), .cpuTaN(cpuTaN), .cpuBusy(cpuBusy), .strobe(strobe)
  );

  xbr_path #(.AW(AW), .DW(DW), .MUX_BUS(MUX_BUS)) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .cpuRw(cpuRw), .cpuSize(cpuSize),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .brdRdData(brdRdData),
    .cpuRdData(cpuRdData), .brdAddr(brdAddr), .brdRw(brdRw), .brdSize(brdSize),
    .brdAd(brdAd), .brdDataOe(brdDataOe)
  );

  assign cpuAvecN = brdAvecN;

  // R10
  avec_pass_chk: assert property (@(posedge clk) disable iff (rst)
    cpuAvecN == brdAvecN);
endmodule

// File: tb/tb_xbr_top.sv
module tb_xbr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpuTsN = 1'b1, cpuRw = 1'b1;
  logic [1:0]  cpuSize = 2'b00;
  logic [31:0] cpuAddr = '0, cpuWrData = '0;
  logic        cpuTaN, cpuBusy, cpuAvecN, brdTsN, brdRw, brdDataOe;
  logic [31:0] cpuRdData, brdAddr, brdAd;
  logic [1:0]  brdSize;
  logic        brdTaN = 1'b1, brdAvecN = 1'b1;
  logic [31:0] brdRdData = '0;

  xbr_top dut (
    .clk(clk), .rst(rst), .cpuTsN(cpuTsN), .cpuRw(cpuRw), .cpuSize(cpuSize),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuTaN(cpuTaN), .cpuRdData(cpuRdData),
    .cpuBusy(cpuBusy), .cpuAvecN(cpuAvecN), .brdTsN(brdTsN), .brdRw(brdRw),
    .brdSize(brdSize), .brdAddr(brdAddr), .brdAd(brdAd), .brdDataOe(brdDataOe),
    .brdTaN(brdTaN), .brdRdData(brdRdData), .brdAvecN(brdAvecN)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int taCount = 0, tsLowCount = 0;
  int waitCfg = 0;

  // reference model state
  int          mSt = 0, mPh = 0, mBeats = 1, mCnt = 0;
  logic        mTs = 1'b1, mTa = 1'b1, mRw = 1'b1;
  logic [1:0]  mSize = 2'b00;
  logic [31:0] mAddr = '0, mRd = '0;
  // board model state
  int bActive = 0, bWait = 0, bLeft = 0, bIdx = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mSt = 0; mPh = 0; mTs = 1'b1; mTa = 1'b1; mRw = 1'b1; mSize = 2'b00;
      mAddr = '0; mRd = '0; mCnt = 0; mBeats = 1;
      bActive = 0; brdTaN <= 1'b1;
    end else begin
      // board reacts on slow edges
      if (mPh == 0) begin
        brdTaN <= 1'b1;
        if (!brdTsN) begin
          bActive = 1; bWait = waitCfg; bLeft = (brdSize == 2'b11) ? 4 : 1;
        end else if (bActive != 0) begin
          if (bWait > 0) bWait--;
          else begin
            brdTaN    <= 1'b0;
            brdRdData <= 32'hB0A0_0000 ^ brdAddr ^ bIdx;
            bIdx++;
            bLeft--;
            if (bLeft == 0) bActive = 0;
          end
        end
      end
      // bridge expectation
      mTa = 1'b1;
      case (mSt)
        0: if (!cpuTsN) begin
             mSt = 1; mAddr = cpuAddr; mRw = cpuRw; mSize = cpuSize;
             mBeats = (cpuSize == 2'b11) ? 4 : 1; mCnt = 0;
           end
        1: if (mPh == 0) begin mTs = 1'b0; mSt = 2; end
        2: if (mPh == 0) begin mTs = 1'b1; mSt = 3; end
        default: if (mPh == 0 && !brdTaN) begin
             mTa = 1'b0; mRd = brdRdData; mCnt++;
             if (mCnt == mBeats) mSt = 0;
           end
      endcase
      mPh = 1 - mPh;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (!cpuTaN) taCount++;
      if (!brdTsN) tsLowCount++;
      chk(cpuTaN == mTa, "R4 cpuTaN", {31'b0, cpuTaN}, {31'b0, mTa});
      chk(brdTsN == mTs, "R3 brdTsN", {31'b0, brdTsN}, {31'b0, mTs});
      chk(cpuBusy == (mSt != 0), "R2 cpuBusy", {31'b0, cpuBusy}, {31'b0, (mSt != 0)});
      chk(brdAddr == mAddr, "R7 brdAddr", brdAddr, mAddr);
      chk(brdRw == mRw, "R7 brdRw", {31'b0, brdRw}, {31'b0, mRw});
      chk(brdSize == mSize, "R7 brdSize", {30'b0, brdSize}, {30'b0, mSize});
      if (!mTa) chk(cpuRdData == mRd, "R5 cpuRdData", cpuRdData, mRd);
      chk(brdAd == (!mTs ? mAddr : cpuWrData), "R8 brdAd", brdAd, (!mTs ? mAddr : cpuWrData));
      chk(brdDataOe == ((mSt != 0) && (!mTs || !mRw)), "R9 brdDataOe",
          {31'b0, brdDataOe}, {31'b0, ((mSt != 0) && (!mTs || !mRw))});
    end
  end

  task automatic xfer(input logic [31:0] a, input logic rw, input logic [1:0] sz,
                      input int w, input int skew, input bit intrude);
    int taBefore, tsBefore, expBeats;
    repeat (skew) @(negedge clk);
    waitCfg = w; taBefore = taCount; tsBefore = tsLowCount;
    expBeats = (sz == 2'b11) ? 4 : 1;
    cpuAddr = a; cpuRw = rw; cpuSize = sz; cpuWrData = ~a; cpuTsN = 1'b0;
    @(negedge clk);
    cpuTsN = 1'b1;
    if (intrude) begin
      repeat (5) @(negedge clk);
      // R2: start strobe while busy must be ignored
      cpuAddr = a ^ 32'h00FF_0000; cpuSize = 2'b00; cpuTsN = 1'b0;
      @(negedge clk);
      cpuTsN = 1'b1; cpuAddr = a;
    end
    while (cpuBusy) @(negedge clk);
    @(negedge clk);
    chk(taCount - taBefore == expBeats, "R6 beat count", taCount - taBefore, expBeats);
    chk(tsLowCount - tsBefore == 2, "R3 strobe width", tsLowCount - tsBefore, 2);
    if (intrude) chk(brdAddr == a, "R2 ignored start", brdAddr, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(brdTsN == 1'b1, "R1 brdTsN", {31'b0, brdTsN}, 1);
    chk(cpuTaN == 1'b1, "R1 cpuTaN", {31'b0, cpuTaN}, 1);
    chk(cpuBusy == 1'b0, "R1 cpuBusy", {31'b0, cpuBusy}, 0);
    rst = 1'b0;
    // R10 autovector passthrough
    for (int k = 0; k < 4; k++) begin
      brdAvecN = k[0];
      #1 chk(cpuAvecN == brdAvecN, "R10 avec", {31'b0, cpuAvecN}, {31'b0, brdAvecN});
      @(negedge clk);
    end
    xfer(32'h1000_0010, 1'b1, 2'b10, 0, 0, 0);   // single read
    xfer(32'h2000_0024, 1'b1, 2'b10, 1, 1, 0);   // single read, other phase
    xfer(32'h3000_0100, 1'b1, 2'b11, 0, 0, 0);   // line read
    xfer(32'h4000_0200, 1'b0, 2'b11, 1, 1, 0);   // line write
    xfer(32'h5000_0004, 1'b0, 2'b00, 2, 0, 0);   // single write
    xfer(32'h6000_0300, 1'b1, 2'b11, 4, 1, 1);   // line read with ignored start
    xfer(32'h7000_0008, 1'b0, 2'b01, 0, 0, 1);   // ignored start after short transfer
    for (int k = 0; k < 6; k++)
      xfer(32'h8000_0000 + k * 16, k[0], (k % 3 == 0) ? 2'b11 : 2'b10, k % 3, k % 2, 0);
    // R1 reset mid-transfer
    cpuAddr = 32'h9000_0000; cpuSize = 2'b11; cpuTsN = 1'b0;
    @(negedge clk); cpuTsN = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(brdTsN == 1'b1 && cpuTaN == 1'b1 && cpuBusy == 1'b0, "R1 reset mid",
        {29'b0, brdTsN, cpuTaN, cpuBusy}, 32'h6);
    rst = 1'b0;
    xfer(32'hA000_0040, 1'b1, 2'b11, 0, 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired t=%0t actual=%h expected=%h", $time, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule